// File: doc/BRIEF.md
# Flash Chip-Select Window Decoder

This block sits between a memory-mapped flash aperture and the serial flash engines behind it. The aperture is shared by up to `NUM_CS` flash devices. Each device owns a programmable segment register that names the first and the last 1 MB block it answers to. Addresses are counted from the base of the aperture.

For every bus address offered on the lookup port, the block returns one registered result one cycle later. The result is either a one-hot chip select together with the byte offset of the address inside that device's segment, or a single-cycle miss flag. Software writes the segment registers through a small configuration port and can read them back.

A register that holds all zeros closes its segment. A segment is inclusive of its last block. When segments overlap, the lowest-numbered chip select takes the address.

Top module: `flwin_decoder`

## Requirements
- R1: After reset every segment register reads back as zero, and any lookup misses with no chip select driven.
- R2: The start block is taken from register bits [11:4] and the end block from bits [27:20], each in 1 MB units. The end block is inclusive, so the last byte of the end block hits and the first byte after it does not.
- R3: A lookup hits chip select n when register n is nonzero and the address block lies between the start block and the end block, both included.
- R4: A register whose value is zero never produces a hit, not even for address zero.
- R5: When several segments hold the address, only the lowest-numbered chip select is driven, and `res_cs` is never more than one-hot.
- R6: On a hit, `res_off` equals the lookup address minus the start block times 1 MB.
- R7: A lookup that hits no segment raises `res_miss` for exactly its one result cycle, with `res_cs` zero.
- R8: Each result appears on the clock edge after `lk_valid` is sampled; `res_valid` is high exactly in those cycles.
- R9: A register write becomes visible to lookups sampled on later edges. A lookup sampled on the same edge as the write still sees the previous contents.
- R10: `cfg_rd_data` shows, one cycle after `cfg_rd_idx` is sampled, the full 32-bit value of the selected register as it stood before any write on that same edge.
- R11: Writes to an index at or above `NUM_CS` are ignored: reading that index returns zero, and no existing segment changes.
- R12: A nonzero register whose start block exceeds its end block matches no address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Segment register write strobe |
| cfg_wr_idx | input | IDX_W | Index of the register to write |
| cfg_wr_data | input | 32 | Value to write |
| cfg_rd_idx | input | IDX_W | Index of the register to read back |
| cfg_rd_data | output | 32 | Read-back value |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Address relative to the aperture base |
| res_valid | output | 1 | Result present |
| res_cs | output | NUM_CS | One-hot selected chip select |
| res_off | output | ADDR_W | Byte offset inside the selected segment |
| res_miss | output | 1 | Lookup matched no segment |

## Verification
The bench builds the block with its defaults: three chip selects, a 28-bit aperture address, 1 MB units and a read-back latency of one cycle. With a 2-bit index, index 3 is a real input value that has no register behind it, so the ignored-write case is reachable. The 28-bit address puts both field positions and the inclusive last block within reach. Random segments are limited to the low 16 blocks so that overlaps, start-after-end registers and exact block edges come up often.

// File: rtl/flwin_pkg.sv
package flwin_pkg;
   localparam int SEG_REG_W  = 32;
   localparam int HALF_SHIFT = 16;
   typedef logic [SEG_REG_W-1:0] seg_word_t;
endpackage

// File: rtl/flwin_seg_regs.sv
module flwin_seg_regs #(
   parameter int NUM_CS       = 3,
   parameter int IDX_W        = 2,
   parameter int READ_LATENCY = 1
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 wr_en,
   input  logic [IDX_W-1:0]                     wr_idx,
   input  flwin_pkg::seg_word_t                 wr_data,
   input  logic [IDX_W-1:0]                     rd_idx,
   output flwin_pkg::seg_word_t                 rd_data,
   output flwin_pkg::seg_word_t [NUM_CS-1:0]    seg_q
);
   flwin_pkg::seg_word_t rd_sel;

   for (genvar i = 0; i < NUM_CS; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            seg_q[i] <= '0;
         else if (wr_en && (wr_idx == IDX_W'(i)))
            seg_q[i] <= wr_data;
      end
   end

   always_comb begin
      rd_sel = '0;
      for (int i = 0; i < NUM_CS; i++)
         if (rd_idx == IDX_W'(i)) rd_sel = seg_q[i];
   end

   if (READ_LATENCY == 0) begin : g_rd_comb
      assign rd_data = rd_sel;
   end else if (READ_LATENCY == 1) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_data <= '0;
         else        rd_data <= rd_sel;
      end
   end else begin : g_rd_bad
      $error("flwin_seg_regs: READ_LATENCY must be 0 or 1");
   end
endmodule

// File: rtl/flwin_match.sv
module flwin_match #(
   parameter int NUM_CS     = 3,
   parameter int ADDR_W     = 28,
   parameter int UNIT_SHIFT = 20,
   localparam int BLK_W     = ADDR_W - UNIT_SHIFT,
   localparam int START_LSB = UNIT_SHIFT - flwin_pkg::HALF_SHIFT,
   localparam int END_LSB   = UNIT_SHIFT
) (
   input  flwin_pkg::seg_word_t [NUM_CS-1:0] seg_q,
   input  logic [ADDR_W-1:0]                 addr,
   output logic [NUM_CS-1:0]                 hit,
   output logic [NUM_CS-1:0][ADDR_W-1:0]     off
);
   logic [BLK_W-1:0] a_blk;
   assign a_blk = addr[ADDR_W-1 -: BLK_W];

   for (genvar i = 0; i < NUM_CS; i++) begin : g_cmp
      logic [BLK_W-1:0] s_blk;
      logic [BLK_W-1:0] e_blk;
      logic             open;
      assign s_blk  = seg_q[i][START_LSB +: BLK_W];
      assign e_blk  = seg_q[i][END_LSB +: BLK_W];
      assign open   = |seg_q[i];
      assign hit[i] = open && (a_blk >= s_blk) && (a_blk <= e_blk);
      assign off[i] = addr - {s_blk, {UNIT_SHIFT{1'b0}}};
   end
endmodule

// File: rtl/flwin_prio.sv
module flwin_prio #(
   parameter int NUM_CS = 3,
   parameter int ADDR_W = 28
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             lk_valid,
   input  logic [NUM_CS-1:0]                hit,
   input  logic [NUM_CS-1:0][ADDR_W-1:0]    off,
   output logic                             res_valid,
   output logic [NUM_CS-1:0]                res_cs,
   output logic [ADDR_W-1:0]                res_off,
   output logic                             res_miss
);
   logic [NUM_CS-1:0] sel_cs;
   logic [ADDR_W-1:0] sel_off;

   always_comb begin
      sel_cs  = '0;
      sel_off = '0;
      for (int i = NUM_CS-1; i >= 0; i--) begin
         if (hit[i]) begin
            sel_cs    = '0;
            sel_cs[i] = 1'b1;
            sel_off   = off[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_cs    <= '0;
         res_off   <= '0;
         res_miss  <= 1'b0;
      end else begin
         res_valid <= lk_valid;
         res_cs    <= lk_valid ? sel_cs : '0;
         res_off   <= lk_valid ? sel_off : '0;
         res_miss  <= lk_valid && !(|hit);
      end
   end
endmodule

// File: rtl/flwin_decoder.sv
module flwin_decoder #(
   parameter int NUM_CS       = 3,
   parameter int ADDR_W       = 28,
   parameter int UNIT_SHIFT   = 20,
   parameter int READ_LATENCY = 1,
   localparam int IDX_W       = (NUM_CS > 1) ? $clog2(NUM_CS + 1) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic [IDX_W-1:0]  cfg_wr_idx,
   input  logic [31:0]       cfg_wr_data,
   input  logic [IDX_W-1:0]  cfg_rd_idx,
   output logic [31:0]       cfg_rd_data,
   input  logic              lk_valid,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              res_valid,
   output logic [NUM_CS-1:0] res_cs,
   output logic [ADDR_W-1:0] res_off,
   output logic              res_miss
);
   localparam int BLK_W = ADDR_W - UNIT_SHIFT;

   if (NUM_CS < 1) begin : g_chk_cs
      $error("flwin_decoder: NUM_CS must be at least 1");
   end
   if (UNIT_SHIFT < flwin_pkg::HALF_SHIFT) begin : g_chk_unit
      $error("flwin_decoder: UNIT_SHIFT below the field split");
   end
   if (BLK_W < 1 || UNIT_SHIFT - flwin_pkg::HALF_SHIFT + BLK_W > flwin_pkg::HALF_SHIFT) begin : g_chk_start
      $error("flwin_decoder: start field does not fit the low half");
   end
   if (UNIT_SHIFT + BLK_W > flwin_pkg::SEG_REG_W) begin : g_chk_end
      $error("flwin_decoder: end field does not fit the register");
   end

   flwin_pkg::seg_word_t [NUM_CS-1:0] seg_q;
   logic [NUM_CS-1:0]                 hit;
   logic [NUM_CS-1:0][ADDR_W-1:0]     off;

   flwin_seg_regs #(
      .NUM_CS(NUM_CS), .IDX_W(IDX_W), .READ_LATENCY(READ_LATENCY)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_wr_en), .wr_idx(cfg_wr_idx), .wr_data(cfg_wr_data),
      .rd_idx(cfg_rd_idx), .rd_data(cfg_rd_data), .seg_q(seg_q)
   );

   flwin_match #(
      .NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .UNIT_SHIFT(UNIT_SHIFT)
   ) u_match (
      .seg_q(seg_q), .addr(lk_addr), .hit(hit), .off(off)
   );

   flwin_prio #(
      .NUM_CS(NUM_CS), .ADDR_W(ADDR_W)
   ) u_prio (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .hit(hit), .off(off),
      .res_valid(res_valid), .res_cs(res_cs), .res_off(res_off), .res_miss(res_miss)
   );
endmodule

// File: rtl/flwin_decoder_chk.sv
module flwin_decoder_chk #(
   parameter int NUM_CS = 3,
   parameter int ADDR_W = 28
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lk_valid,
   input logic              res_valid,
   input logic [NUM_CS-1:0] res_cs,
   input logic              res_miss
);
   // R8
   result_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> res_valid);
   // R8
   no_result_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !res_valid);
   // R5
   cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(res_cs));
   // R7
   miss_drives_no_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_miss |-> (res_valid && (res_cs == '0)));
   // R3
   hit_has_one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_miss) |-> ($countones(res_cs) == 1));
   // R7
   idle_is_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> (!res_miss && (res_cs == '0)));
endmodule

bind flwin_decoder flwin_decoder_chk #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .res_valid(res_valid),
   .res_cs(res_cs), .res_miss(res_miss)
);

// File: tb/flwin_decoder_tb.sv
module flwin_decoder_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NUM_CS     = 3;
   localparam int ADDR_W     = 28;
   localparam int IDX_W      = 2;
   localparam int N_RAND     = 3000;
   localparam int SEED       = 1234;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_wr_en = 1'b0;
   logic [IDX_W-1:0]  cfg_wr_idx = '0;
   logic [31:0]       cfg_wr_data = '0;
   logic [IDX_W-1:0]  cfg_rd_idx = '0;
   logic [31:0]       cfg_rd_data;
   logic              lk_valid = 1'b0;
   logic [ADDR_W-1:0] lk_addr = '0;
   logic              res_valid;
   logic [NUM_CS-1:0] res_cs;
   logic [ADDR_W-1:0] res_off;
   logic              res_miss;

   always #(CLK_PERIOD/2) clk = ~clk;

   flwin_decoder u_dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx), .cfg_wr_data(cfg_wr_data),
      .cfg_rd_idx(cfg_rd_idx), .cfg_rd_data(cfg_rd_data),
      .lk_valid(lk_valid), .lk_addr(lk_addr),
      .res_valid(res_valid), .res_cs(res_cs), .res_off(res_off), .res_miss(res_miss)
   );

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [31:0] model [4];

   logic              p_valid = 1'b0;
   logic [NUM_CS-1:0] p_cs = '0;
   logic [ADDR_W-1:0] p_off = '0;
   logic              p_miss = 1'b0;
   logic [31:0]       p_rd = '0;
   string             p_tag = "R1";
   string             p_rtag = "R10";

   function automatic void predict(input logic [ADDR_W-1:0] a,
                                   output logic [NUM_CS-1:0] cs,
                                   output logic [ADDR_W-1:0] off,
                                   output logic miss);
      logic [7:0] ab;
      ab   = a[27:20];
      cs   = '0;
      off  = '0;
      miss = 1'b1;
      for (int i = NUM_CS-1; i >= 0; i--) begin
         if (model[i] != 0 && ab >= model[i][11:4] && ab <= model[i][27:20]) begin
            cs      = '0;
            cs[i]   = 1'b1;
            off     = a - {model[i][11:4], 20'h0};
            miss    = 1'b0;
         end
      end
   endfunction

   function automatic logic [31:0] seg(input int s, input int e);
      return (32'(e & 255) << 20) | (32'(s & 255) << 4);
   endfunction

   task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req, input string what);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic step(input logic we, input logic [IDX_W-1:0] widx, input logic [31:0] wdata,
                       input logic [IDX_W-1:0] ridx, input logic lv, input logic [ADDR_W-1:0] a,
                       input string tag, input string rtag);
      logic [NUM_CS-1:0] cs;
      logic [ADDR_W-1:0] off;
      logic              miss;
      @(negedge clk);
      chk(64'(res_valid), 64'(p_valid), "R8", "res_valid");
      chk(64'(res_cs), 64'(p_cs), p_tag, "res_cs");
      chk(64'(res_miss), 64'(p_miss), (p_valid && p_miss) ? "R7" : p_tag, "res_miss");
      if (p_valid && !p_miss) chk(64'(res_off), 64'(p_off), "R6", "res_off");
      chk(64'(cfg_rd_data), 64'(p_rd), p_rtag, "cfg_rd_data");
      predict(a, cs, off, miss);
      p_valid = lv;
      p_cs    = lv ? cs : '0;
      p_off   = off;
      p_miss  = lv && miss;
      p_tag   = tag;
      p_rd    = model[ridx];
      p_rtag  = rtag;
      if (we && widx < NUM_CS) model[widx] = wdata;
      cfg_wr_en   = we;
      cfg_wr_idx  = widx;
      cfg_wr_data = wdata;
      cfg_rd_idx  = ridx;
      lk_valid    = lv;
      lk_addr     = a;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 4; i++) model[i] = '0;
      void'($urandom(SEED));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state of outputs and registers
      chk(64'(res_valid), 0, "R1", "res_valid after reset");
      chk(64'(res_cs), 0, "R1", "res_cs after reset");
      chk(64'(cfg_rd_data), 0, "R1", "cfg_rd_data after reset");
      step(0, 0, 0, 0, 1, 28'h0000000, "R1", "R1");
      step(0, 0, 0, 1, 1, 28'h0123456, "R1", "R1");
      step(0, 0, 0, 2, 1, 28'h0FFFFFF, "R1", "R1");
      // R9: write cs0 = blocks 2..3, lookup in same cycle sees old value
      step(1, 0, seg(2, 3), 0, 1, 28'h0200000, "R9", "R10");
      step(0, 0, 0, 0, 1, 28'h0200000, "R9", "R10");
      // R2: inclusive end block, field positions
      step(0, 0, 0, 0, 1, 28'h03FFFFF, "R2", "R10");
      step(0, 0, 0, 0, 1, 28'h0400000, "R2", "R10");
      step(0, 0, 0, 0, 1, 28'h01FFFFF, "R2", "R10");
      // R5: overlapping cs1 = blocks 3..6
      step(1, 1, seg(3, 6), 1, 0, 0, "R5", "R10");
      step(0, 0, 0, 1, 1, 28'h0350000, "R5", "R10");
      step(0, 0, 0, 0, 1, 28'h0450000, "R6", "R10");
      // R4: cs2 closed with zero
      step(1, 2, 32'h0, 2, 1, 28'h0000000, "R4", "R10");
      step(0, 0, 0, 2, 1, 28'h0000000, "R4", "R10");
      // R12: start after end
      step(1, 2, seg(9, 7), 2, 0, 0, "R12", "R10");
      step(0, 0, 0, 2, 1, 28'h0800000, "R12", "R10");
      step(0, 0, 0, 2, 1, 28'h0700000, "R12", "R10");
      step(0, 0, 0, 2, 1, 28'h0900000, "R12", "R10");
      // R11: write to index 3 ignored
      step(1, 3, 32'h0FF00000, 3, 0, 0, "R11", "R11");
      step(0, 0, 0, 3, 1, 28'h0A00000, "R11", "R11");
      step(0, 0, 0, 0, 1, 28'h0350000, "R11", "R11");
      step(0, 0, 0, 1, 0, 0, "R11", "R11");
      // R4: closing cs0 hands block 3 to cs1
      step(1, 0, 32'h0, 0, 0, 0, "R4", "R10");
      step(0, 0, 0, 0, 1, 28'h0350000, "R4", "R10");
      // R3: random mix
      for (int n = 0; n < N_RAND; n++) begin
         logic              we;
         logic [IDX_W-1:0]  widx;
         logic [31:0]       wd;
         logic [ADDR_W-1:0] a;
         int                s;
         int                r;
         r    = int'($urandom % 8);
         s    = int'($urandom % 16);
         we   = ($urandom % 4) == 0;
         widx = IDX_W'($urandom % 4);
         if (r == 0)      wd = 32'h0;
         else if (r == 1) wd = $urandom;
         else             wd = seg(s, s + int'($urandom % 5) - 1);
         if (($urandom % 8) == 0) a = ADDR_W'($urandom);
         else a = {8'($urandom % 18), 20'($urandom)};
         step(we, widx, wd, IDX_W'($urandom % 4), ($urandom % 5) != 0, a, "R3", "R10");
      end
      step(0, 0, 0, 0, 0, 0, "R8", "R10");
      step(0, 0, 0, 0, 0, 0, "R8", "R10");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule